// File: doc/BRIEF.md
# Multi-Ratio Clock Divider Bank with Coincidence Warning

This block divides one fast reference clock into four registered square waves: three output banks (A, B, C) and one feedback output. Each bank picks its divide ratio from a small fixed set through its own select code. Every ratio is even, so every output has an exact 50% duty cycle. All outputs come straight from flops, so they cannot glitch.

The block also tracks the phase of banks A and C and drives an active-low warning, `sync_n`. The warning covers one period of the faster of the two banks, and that period ends just before A and C rise on the same reference edge.

Select codes are sampled at any time, but a new ratio only takes effect on an edge where all four outputs rise together. This prevents runt pulses. After reset, all outputs start in phase.

Top module: `ratio_div_bank`

## Requirements
- R1: Bank A select codes 0, 1, 2 and 3 divide the reference by 4, 6, 8 and 12.
- R2: Bank B select codes 0, 1, 2 and 3 divide the reference by 4, 6, 8 and 10.
- R3: Bank C select codes 0, 1, 2 and 3 divide the reference by 2, 4, 6 and 8.
- R4: The feedback select is 3 bits. When bit 2 is 0, codes 0 to 3 in bits 1:0 divide by 4, 6, 8 and 10. When bit 2 is 1, the same low codes divide by 8, 12, 16 and 20.
- R5: An output with ratio N is high for the first N/2 reference cycles of each period and low for the remaining N/2. Each rising edge falls on the first cycle of a period.
- R6: While `rst_n` is low, all four outputs are low. On the first rising reference edge with `rst_n` high, all four outputs rise together. This is edge 0, and its selects set the starting ratios.
- R7: A select change has no effect until the next reference edge on which all four outputs rise together. That edge begins the new ratios. Until then, every output keeps its previous ratio and phase.
- R8: Let P be the least common multiple of the A and C ratios, and F the smaller of the two. Counting edges from the last point where all four banks aligned, `sync_n` is low in the cycles that follow edges P·m−F through P·m−1. It is high in all other cycles. The A/C rising edge therefore always falls at the end of a low stretch of exactly F cycles.
- R9: R8 holds for all 16 combinations of the A and C selects. When A and C have equal ratios, P equals F, so `sync_n` stays low continuously while running.
- R10: `sync_n` is high while `rst_n` is low, and it stays high in the cycle before edge 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| div_a | output | 1 | Bank A divided clock |
| div_b | output | 1 | Bank B divided clock |
| div_c | output | 1 | Bank C divided clock |
| div_fb | output | 1 | Feedback divided clock |
| sync_n | output | 1 | Active-low warning ahead of an A/C coincident rise |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is synchronous and held low for at least one edge before the dividers start.
- Every configured ratio is even and at least 2. Elaboration checks confirm this.

The select inputs may change in any cycle, since the block itself defers their use. The stimulus therefore changes selects, and releases or asserts reset, only one time unit after a rising edge, well away from any sampling edge. It also deliberately changes selects in the middle of long common periods, so the deferral path is exercised against the reference model.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;

   localparam int RATIO_W = 5;

   // entry i of each set sits at bits [i*RATIO_W +: RATIO_W]
   localparam logic [4*RATIO_W-1:0] A_SET  = {5'd12, 5'd8, 5'd6, 5'd4};
   localparam logic [4*RATIO_W-1:0] B_SET  = {5'd10, 5'd8, 5'd6, 5'd4};
   localparam logic [4*RATIO_W-1:0] C_SET  = {5'd8,  5'd6, 5'd4, 5'd2};
   localparam logic [8*RATIO_W-1:0] FB_SET = {5'd20, 5'd16, 5'd12, 5'd8,
                                              5'd10, 5'd8,  5'd6,  5'd4};

   function automatic int gcd_f(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int lcm_f(input int a, input int b);
      return (a / gcd_f(a, b)) * b;
   endfunction

   function automatic int min_f(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/div_lane.sv
module div_lane #(
   parameter int SEL_W = 2,
   parameter int RW    = 5,
   parameter logic [(2**SEL_W)*RW-1:0] RATIOS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             take,
   input  logic [SEL_W-1:0] sel_in,
   output logic             lane_out,
   output logic             at_end,
   output logic [SEL_W-1:0] sel_act
);

   localparam int NSEL = 2**SEL_W;

   generate
      for (genvar i = 0; i < NSEL; i++) begin : g_chk
         localparam logic [RW-1:0] R = RATIOS[i*RW +: RW];
         if (R < 2 || R[0]) begin : g_bad
            $error("div_lane: ratio %0d must be even and at least 2", R);
         end
      end
   endgenerate

   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] sel_nxt;
   logic [RW-1:0]    cnt_q;
   logic [RW-1:0]    cnt_nxt;
   logic [RW-1:0]    cur_ratio;
   logic [RW-1:0]    nxt_ratio;
   logic             out_q;

   always_comb begin
      cur_ratio = RATIOS[sel_q*RW +: RW];
      sel_nxt   = take ? sel_in : sel_q;
      nxt_ratio = RATIOS[sel_nxt*RW +: RW];
      at_end    = (cnt_q == cur_ratio - 1'b1);
      cnt_nxt   = (!run || at_end) ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         cnt_q <= '0;
         out_q <= 1'b0;
      end else begin
         sel_q <= sel_nxt;
         cnt_q <= cnt_nxt;
         out_q <= (cnt_nxt < (nxt_ratio >> 1));
      end
   end

   assign lane_out = out_q;
   assign sel_act  = sel_q;

   // R5: a rising edge marks the first cycle of a period
   a_r5_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> (cnt_q == '0));

   // R5: the phase counter never leaves the active period
   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < cur_ratio));

endmodule

// File: rtl/coin_warn.sv
module coin_warn #(
   parameter int SA_W = 2,
   parameter int SC_W = 2,
   parameter int RW   = 5,
   parameter logic [(2**SA_W)*RW-1:0] A_RATIOS = '0,
   parameter logic [(2**SC_W)*RW-1:0] C_RATIOS = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            a_end,
   input  logic            c_end,
   input  logic [SA_W-1:0] sel_a_nxt,
   input  logic [SC_W-1:0] sel_c_nxt,
   output logic            sync_n
);

   localparam int NA = 2**SA_W;
   localparam int NC = 2**SC_W;
   localparam int NE = NA * NC;
   localparam int PW = 2 * RW;

   function automatic logic [NE*PW-1:0] mk_tbl(input bit want_period);
      logic [NE*PW-1:0] t;
      t = '0;
      for (int ia = 0; ia < NA; ia++) begin
         for (int ic = 0; ic < NC; ic++) begin
            int ra;
            int rc;
            ra = int'(A_RATIOS[ia*RW +: RW]);
            rc = int'(C_RATIOS[ic*RW +: RW]);
            t[(ia*NC + ic)*PW +: PW] = want_period ? PW'(ratio_div_pkg::lcm_f(ra, rc))
                                                   : PW'(ratio_div_pkg::min_f(ra, rc));
         end
      end
      return t;
   endfunction

   localparam logic [NE*PW-1:0] P_TBL = mk_tbl(1'b1);
   localparam logic [NE*PW-1:0] F_TBL = mk_tbl(1'b0);

   generate
      if (NE > 1024) begin : g_big
         $error("coin_warn: select space too large for a lookup table");
      end
   endgenerate

   logic [PW-1:0] ac_q;
   logic [PW-1:0] ac_nxt;
   logic [PW-1:0] per;
   logic [PW-1:0] fast;
   logic          sync_q;

   always_comb begin
      ac_nxt = (!run || (a_end && c_end)) ? '0 : ac_q + 1'b1;
      per    = P_TBL[{sel_a_nxt, sel_c_nxt}*PW +: PW];
      fast   = F_TBL[{sel_a_nxt, sel_c_nxt}*PW +: PW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac_q   <= '0;
         sync_q <= 1'b1;
      end else begin
         ac_q   <= ac_nxt;
         sync_q <= !(ac_nxt >= per - fast);
      end
   end

   assign sync_n = sync_q;

   // R8: the cycle before A and C wrap together is always flagged
   a_r8_low_before_coin: assert property (@(posedge clk) disable iff (!rst_n)
      (run && a_end && c_end) |-> !sync_q);

   // R10: no warning before the dividers start
   a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> sync_q);

endmodule

// File: rtl/ratio_div_bank.sv
module ratio_div_bank
   import ratio_div_pkg::*;
#(
   parameter int A_SEL_W  = 2,
   parameter int B_SEL_W  = 2,
   parameter int C_SEL_W  = 2,
   parameter int FB_SEL_W = 3,
   parameter int RW       = RATIO_W,
   parameter logic [(2**A_SEL_W)*RW-1:0]  A_RATIOS  = A_SET,
   parameter logic [(2**B_SEL_W)*RW-1:0]  B_RATIOS  = B_SET,
   parameter logic [(2**C_SEL_W)*RW-1:0]  C_RATIOS  = C_SET,
   parameter logic [(2**FB_SEL_W)*RW-1:0] FB_RATIOS = FB_SET
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [A_SEL_W-1:0]  sel_a,
   input  logic [B_SEL_W-1:0]  sel_b,
   input  logic [C_SEL_W-1:0]  sel_c,
   input  logic [FB_SEL_W-1:0] sel_fb,
   output logic                div_a,
   output logic                div_b,
   output logic                div_c,
   output logic                div_fb,
   output logic                sync_n
);

   logic                run_q;
   logic                align;
   logic                take;
   logic                a_end, b_end, c_end, f_end;
   logic [A_SEL_W-1:0]  a_act;
   logic [B_SEL_W-1:0]  b_act;
   logic [C_SEL_W-1:0]  c_act;
   logic [FB_SEL_W-1:0] f_act;
   logic [A_SEL_W-1:0]  a_nxt;
   logic [C_SEL_W-1:0]  c_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   assign align = run_q & a_end & b_end & c_end & f_end;
   assign take  = !run_q | align;
   assign a_nxt = take ? sel_a : a_act;
   assign c_nxt = take ? sel_c : c_act;

   div_lane #(.SEL_W(A_SEL_W), .RW(RW), .RATIOS(A_RATIOS)) u_lane_a (
      .clk(clk), .rst_n(rst_n), .run(run_q), .take(take), .sel_in(sel_a),
      .lane_out(div_a), .at_end(a_end), .sel_act(a_act));

   div_lane #(.SEL_W(B_SEL_W), .RW(RW), .RATIOS(B_RATIOS)) u_lane_b (
      .clk(clk), .rst_n(rst_n), .run(run_q), .take(take), .sel_in(sel_b),
      .lane_out(div_b), .at_end(b_end), .sel_act(b_act));

   div_lane #(.SEL_W(C_SEL_W), .RW(RW), .RATIOS(C_RATIOS)) u_lane_c (
      .clk(clk), .rst_n(rst_n), .run(run_q), .take(take), .sel_in(sel_c),
      .lane_out(div_c), .at_end(c_end), .sel_act(c_act));

   div_lane #(.SEL_W(FB_SEL_W), .RW(RW), .RATIOS(FB_RATIOS)) u_lane_fb (
      .clk(clk), .rst_n(rst_n), .run(run_q), .take(take), .sel_in(sel_fb),
      .lane_out(div_fb), .at_end(f_end), .sel_act(f_act));

   coin_warn #(.SA_W(A_SEL_W), .SC_W(C_SEL_W), .RW(RW),
               .A_RATIOS(A_RATIOS), .C_RATIOS(C_RATIOS)) u_warn (
      .clk(clk), .rst_n(rst_n), .run(run_q), .a_end(a_end), .c_end(c_end),
      .sel_a_nxt(a_nxt), .sel_c_nxt(c_nxt), .sync_n(sync_n));

   // R6: every output rises on the start edge
   a_r6_start_together: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !$past(run_q)) |-> (div_a && div_b && div_c && div_fb));

   // R7: active selects hold between alignment edges
   a_r7_hold_selects: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !align) |=> $stable({a_act, b_act, c_act, f_act}));

endmodule

// File: tb/ratio_div_bank_test.sv
module ratio_div_bank_test;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n;
   logic [1:0] sel_a, sel_b, sel_c;
   logic [2:0] sel_fb;
   logic       div_a, div_b, div_c, div_fb, sync_n;

   ratio_div_bank uut (
      .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
      .sel_fb(sel_fb), .div_a(div_a), .div_b(div_b), .div_c(div_c),
      .div_fb(div_fb), .sync_n(sync_n));

   typedef struct {
      logic  a, b, c, f, s;
      string ph;
   } exp_t;

   exp_t  sb[$];
   int    checks = 0;
   int    errors = 0;
   bit    done   = 0;
   string phase  = "R6 R10";

   // reference model state
   bit started = 0;
   int ca, cb, cc, cf, acc, ra, rb, rc, rf;

   function automatic int rat_a(input logic [1:0] s);
      case (s) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 12; endcase
   endfunction
   function automatic int rat_b(input logic [1:0] s);
      case (s) 2'd0: return 4; 2'd1: return 6; 2'd2: return 8; default: return 10; endcase
   endfunction
   function automatic int rat_c(input logic [1:0] s);
      case (s) 2'd0: return 2; 2'd1: return 4; 2'd2: return 6; default: return 8; endcase
   endfunction
   function automatic int rat_f(input logic [2:0] s);
      int base;
      case (s[1:0]) 2'd0: base = 4; 2'd1: base = 6; 2'd2: base = 8; default: base = 10; endcase
      return s[2] ? 2 * base : base;
   endfunction
   function automatic int tb_lcm(input int a, input int b);
      int m;
      m = a;
      while (m % b != 0) m = m + a;
      return m;
   endfunction

   task automatic load_ratios();
      ra = rat_a(sel_a); rb = rat_b(sel_b); rc = rat_c(sel_c); rf = rat_f(sel_fb);
   endtask

   // driver: one reference edge, predicted result pushed to the scoreboard
   task automatic tick();
      exp_t e;
      bit   al, co;
      int   p, nf;
      @(posedge clk);
      #1;
      e.ph = phase;
      if (!rst_n) begin
         started = 0;
         e.a = 0; e.b = 0; e.c = 0; e.f = 0; e.s = 1;
      end else begin
         if (!started) begin
            started = 1;
            load_ratios();
            ca = 0; cb = 0; cc = 0; cf = 0; acc = 0;
         end else begin
            al = (ca == ra-1) && (cb == rb-1) && (cc == rc-1) && (cf == rf-1);
            co = (ca == ra-1) && (cc == rc-1);
            ca = (ca == ra-1) ? 0 : ca + 1;
            cb = (cb == rb-1) ? 0 : cb + 1;
            cc = (cc == rc-1) ? 0 : cc + 1;
            cf = (cf == rf-1) ? 0 : cf + 1;
            acc = co ? 0 : acc + 1;
            if (al) load_ratios();
         end
         p  = tb_lcm(ra, rc);
         nf = (ra < rc) ? ra : rc;
         e.a = (ca < ra/2); e.b = (cb < rb/2); e.c = (cc < rc/2); e.f = (cf < rf/2);
         e.s = !(acc >= p - nf);
      end
      sb.push_back(e);
   endtask

   task automatic chk(input string req, input string ph, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s [%s] got %b exp %b at %0t", req, ph, got, exp, $time);
      end
   endtask

   // monitor: compares half a cycle after each edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk("R1 div_a",  e.ph, div_a,  e.a);
         chk("R2 div_b",  e.ph, div_b,  e.b);
         chk("R3 div_c",  e.ph, div_c,  e.c);
         chk("R4 div_fb", e.ph, div_fb, e.f);
         chk("R8 sync_n", e.ph, sync_n, e.s);
      end
   end

   task automatic restart(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c,
                          input logic [2:0] f, input string ph);
      phase = "R6 R10";
      rst_n = 1'b0;
      tick();
      tick();
      sel_a = a; sel_b = b; sel_c = c; sel_fb = f;
      rst_n = 1'b1;
      phase = ph;
   endtask

   initial begin
      rst_n = 1'b0;
      sel_a = 2'd0; sel_b = 2'd0; sel_c = 2'd0; sel_fb = 3'd0;
      repeat (3) tick();                 // R6 R10: reset state
      rst_n = 1'b1;
      phase = "R5 R6";
      repeat (30) tick();                // start edge and steady duty

      // R7: changes mid common period are deferred to the 120-cycle alignment
      restart(2'd3, 2'd3, 2'd3, 3'd7, "R7");
      repeat (7) tick();
      sel_a = 2'd0; sel_b = 2'd0; sel_c = 2'd1; sel_fb = 3'd1;
      repeat (130) tick();
      sel_a = 2'd2; sel_b = 2'd1; sel_c = 2'd2; sel_fb = 3'd5;
      repeat (40) tick();

      // R7: change on a short common period
      restart(2'd0, 2'd0, 2'd0, 3'd0, "R7");
      repeat (3) tick();
      sel_a = 2'd1; sel_c = 2'd3; sel_fb = 3'd4;
      repeat (60) tick();

      // R9: every A/C pairing, with B and feedback codes swept alongside (R4 upper half too)
      for (int i = 0; i < 16; i++) begin
         restart(2'(i >> 2), 2'(i), 2'(i), 3'(i), "R9");
         repeat (60) tick();
      end

      // R10: reset mid-run drops the warning and outputs at once
      phase = "R10";
      rst_n = 1'b0;
      repeat (2) tick();
      rst_n = 1'b1;
      phase = "R5";
      repeat (20) tick();

      @(negedge clk);
      #1;
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule